// File: doc/BRIEF.md
# Relocatable I/O Page Bus Cycle Steering

This block sits between a 24-bit address, asynchronous-strobe CPU and an expansion bus. It classifies every bus cycle into one of three targets. The first is ordinary memory, which goes out as an expansion-bus memory cycle. The second is port I/O, used for cycles inside a 64 KB I/O page. The third is a local memory-management unit register window, which is the top 64 bytes of that page.

A strap input selects where the I/O page sits. In the low position the page starts at 0x7F0000, and in the high position it starts at 0xFF0000. The block drives the bus status lines, the 16-bit port number, the MMU chip select and a strobe-inhibit gate. It also returns the data acknowledge to the CPU, taking it from the ready line of the selected target.

The control is a single state machine with five states:
- `ST_IDLE` waits for address strobe and samples the strap.
- `ST_MEM` and `ST_PIO` wait for bus ready.
- `ST_MMU` waits for MMU ready.
- `ST_ACK` holds the acknowledge until address strobe is removed.

The transitions are as follows:
- `ST_IDLE` goes to `ST_MEM`, `ST_PIO` or `ST_MMU` when strobe falls, according to the decode.
- Each target state goes to `ST_ACK` when its own ready is seen.
- Every non-idle state returns to `ST_IDLE` once strobe is high; this return takes priority over ready.

Top module: `iosteer_top`

## Requirements
- R1: During and right after reset, every output is low and the strap is taken as the low position (page at 0x7F0000).
- R2: A cycle whose upper address byte equals the selected page (0x7F for strap low, 0xFF for strap high) and whose offset is at most 0xFFBF asserts io_rd_o when rw_i is 1 (read) or io_wr_o when rw_i is 0 (write), in the clock after address strobe falls.
- R3: During a port I/O cycle, port_o carries the low 16 address bits captured at the start of the cycle; at all other times it is zero.
- R4: A cycle with offset 0xFFC0 to 0xFFFF in the selected page asserts mmu_cs_o and strobe_gate_o and no status output.
- R5: A cycle outside the selected page asserts mem_rd_o (read) or mem_wr_o (write), and io_rd_o and io_wr_o stay low. At most one status output is high at a time.
- R6: The strap is sampled only in idle while address strobe is high. A strap change made while strobe is low, followed by a single strobe-high clock, does not affect the next cycle's decode.
- R7: dtack_o follows mmu_rdy_i in an MMU cycle and bus_rdy_i in memory and I/O cycles. The ready of the other target has no effect on dtack_o. Once ready is seen, dtack_o stays high until strobe is removed.
- R8: dtack_o and all status outputs drop within one clock after address strobe goes high.
- R9: mmu_cs_o drops in the clock after MMU ready is seen. strobe_gate_o stays high for the whole MMU cycle, until address strobe is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 24 | CPU address |
| as_n_i | input | 1 | Address strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| strap_hi_i | input | 1 | I/O page position: 1 = 0xFF0000, 0 = 0x7F0000 |
| bus_rdy_i | input | 1 | Expansion-bus ready |
| mmu_rdy_i | input | 1 | MMU transfer complete |
| mem_rd_o | output | 1 | Memory-read status |
| mem_wr_o | output | 1 | Memory-write status |
| io_rd_o | output | 1 | Input status |
| io_wr_o | output | 1 | Output status |
| port_o | output | 16 | Port number |
| mmu_cs_o | output | 1 | MMU chip select |
| strobe_gate_o | output | 1 | Holds expansion-bus strobes off |
| dtack_o | output | 1 | Data acknowledge to CPU |

## Verification
The bound checker evaluates several rules on every clock:
- the status outputs are mutually exclusive;
- the MMU select implies the gate and the absence of status;
- the acknowledge follows MMU ready while the MMU select is high;
- the acknowledge clears after strobe is removed;
- the gate falls only after strobe is removed;
- the sampled strap holds while strobe is low.

Some behaviour can only be shown by the bench's scenarios. This covers:
- the page decode for both strap positions;
- the window edges at offsets 0xFFBF and 0xFFC0;
- the port number value;
- ignoring the wrong ready line;
- the strap change during a cycle followed by a back-to-back cycle.

// File: rtl/iosteer_pkg.sv
package iosteer_pkg;
    typedef enum logic [1:0] {TGT_MEM, TGT_PIO, TGT_MMU} tgt_e;
    typedef enum logic [2:0] {ST_IDLE, ST_MEM, ST_PIO, ST_MMU, ST_ACK} st_e;
endpackage

// File: rtl/iosteer_classify.sv
module iosteer_classify
    import iosteer_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 16,
    parameter int WIN_W  = 6,
    parameter logic [ADDR_W-OFF_W-1:0] LO_PAGE = 'h7F,
    parameter logic [ADDR_W-OFF_W-1:0] HI_PAGE = 'hFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strap_hi_i,
    output tgt_e              tgt_o
);
    localparam int PG_W = ADDR_W - OFF_W;

    logic [PG_W-1:0]  page;
    logic [OFF_W-1:0] off;
    logic [PG_W-1:0]  base;

    assign page = addr_i[ADDR_W-1:OFF_W];
    assign off  = addr_i[OFF_W-1:0];
    assign base = strap_hi_i ? HI_PAGE : LO_PAGE;

    always_comb begin
        if (page != base)
            tgt_o = TGT_MEM;
        else if (&off[OFF_W-1:WIN_W])
            tgt_o = TGT_MMU;
        else
            tgt_o = TGT_PIO;
    end
endmodule

// File: rtl/iosteer_fsm.sv
module iosteer_fsm
    import iosteer_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n_i,
    input  logic             rw_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             strap_hi_i,
    input  tgt_e             tgt_i,
    input  logic             bus_rdy_i,
    input  logic             mmu_rdy_i,
    output logic             strap_q_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic             io_rd_o,
    output logic             io_wr_o,
    output logic [OFF_W-1:0] port_o,
    output logic             mmu_cs_o,
    output logic             strobe_gate_o,
    output logic             dtack_o
);
    st_e              st_q, st_d;
    tgt_e             tgt_q;
    logic             rw_q;
    logic [OFF_W-1:0] port_q;
    logic             start;
    logic             busy;

    assign start = (st_q == ST_IDLE) && !as_n_i;
    assign busy  = (st_q != ST_IDLE);

    // state register and cycle capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            tgt_q     <= TGT_MEM;
            rw_q      <= 1'b1;
            port_q    <= '0;
            strap_q_o <= 1'b0;
        end else begin
            st_q <= st_d;
            if ((st_q == ST_IDLE) && as_n_i)
                strap_q_o <= strap_hi_i;
            if (start) begin
                tgt_q  <= tgt_i;
                rw_q   <= rw_i;
                port_q <= off_i;
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!as_n_i) begin
                    unique case (tgt_i)
                        TGT_PIO: st_d = ST_PIO;
                        TGT_MMU: st_d = ST_MMU;
                        default: st_d = ST_MEM;
                    endcase
                end
            end
            ST_MEM, ST_PIO: begin
                if (as_n_i)         st_d = ST_IDLE;
                else if (bus_rdy_i) st_d = ST_ACK;
            end
            ST_MMU: begin
                if (as_n_i)         st_d = ST_IDLE;
                else if (mmu_rdy_i) st_d = ST_ACK;
            end
            ST_ACK: begin
                if (as_n_i)         st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_rd_o      = busy && (tgt_q == TGT_MEM) && rw_q;
        mem_wr_o      = busy && (tgt_q == TGT_MEM) && !rw_q;
        io_rd_o       = busy && (tgt_q == TGT_PIO) && rw_q;
        io_wr_o       = busy && (tgt_q == TGT_PIO) && !rw_q;
        port_o        = (busy && (tgt_q == TGT_PIO)) ? port_q : '0;
        mmu_cs_o      = (st_q == ST_MMU);
        strobe_gate_o = busy && (tgt_q == TGT_MMU);
        unique case (st_q)
            ST_MEM, ST_PIO: dtack_o = bus_rdy_i;
            ST_MMU:         dtack_o = mmu_rdy_i;
            ST_ACK:         dtack_o = 1'b1;
            default:        dtack_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/iosteer_top.sv
module iosteer_top
    import iosteer_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 16,
    parameter int WIN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              as_n_i,
    input  logic              rw_i,
    input  logic              strap_hi_i,
    input  logic              bus_rdy_i,
    input  logic              mmu_rdy_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              io_rd_o,
    output logic              io_wr_o,
    output logic [OFF_W-1:0]  port_o,
    output logic              mmu_cs_o,
    output logic              strobe_gate_o,
    output logic              dtack_o
);
    localparam int PG_W = ADDR_W - OFF_W;
    localparam logic [PG_W-1:0] PAGE_LO = {1'b0, {(PG_W-1){1'b1}}};
    localparam logic [PG_W-1:0] PAGE_HI = {PG_W{1'b1}};

    tgt_e tgt;
    logic strap_q;

    iosteer_classify #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .WIN_W  (WIN_W),
        .LO_PAGE(PAGE_LO),
        .HI_PAGE(PAGE_HI)
    ) classify_i (
        .addr_i    (addr_i),
        .strap_hi_i(strap_q),
        .tgt_o     (tgt)
    );

    iosteer_fsm #(.OFF_W(OFF_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .as_n_i       (as_n_i),
        .rw_i         (rw_i),
        .off_i        (addr_i[OFF_W-1:0]),
        .strap_hi_i   (strap_hi_i),
        .tgt_i        (tgt),
        .bus_rdy_i    (bus_rdy_i),
        .mmu_rdy_i    (mmu_rdy_i),
        .strap_q_o    (strap_q),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .io_rd_o      (io_rd_o),
        .io_wr_o      (io_wr_o),
        .port_o       (port_o),
        .mmu_cs_o     (mmu_cs_o),
        .strobe_gate_o(strobe_gate_o),
        .dtack_o      (dtack_o)
    );
endmodule

// File: rtl/iosteer_chk.sv
module iosteer_chk (
    input logic clk,
    input logic rst_n,
    input logic as_n_i,
    input logic mmu_rdy_i,
    input logic strap_q,
    input logic mem_rd_o,
    input logic mem_wr_o,
    input logic io_rd_o,
    input logic io_wr_o,
    input logic mmu_cs_o,
    input logic strobe_gate_o,
    input logic dtack_o
);
    // R5
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}));

    // R4
    mmu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_cs_o |-> (strobe_gate_o && !mem_rd_o && !mem_wr_o && !io_rd_o && !io_wr_o));

    // R7
    mmu_ack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_cs_o |-> (dtack_o == mmu_rdy_i));

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_n_i |=> (!dtack_o && !mem_rd_o && !mem_wr_o && !io_rd_o && !io_wr_o));

    // R9
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_gate_o) |-> $past(as_n_i));

    // R6
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n_i |=> $stable(strap_q));
endmodule

bind iosteer_top iosteer_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .as_n_i       (as_n_i),
    .mmu_rdy_i    (mmu_rdy_i),
    .strap_q      (strap_q),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .io_rd_o      (io_rd_o),
    .io_wr_o      (io_wr_o),
    .mmu_cs_o     (mmu_cs_o),
    .strobe_gate_o(strobe_gate_o),
    .dtack_o      (dtack_o)
);

// File: tb/iosteer_top_tb_top.sv
module iosteer_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        as_n = 1'b1;
    logic        rw = 1'b1;
    logic        strap = 1'b0;
    logic        bus_rdy = 1'b0;
    logic        mmu_rdy = 1'b0;
    logic        mem_rd, mem_wr, io_rd, io_wr, mmu_cs, gate, dtack;
    logic [15:0] port;

    int n_chk = 0;
    int n_bad = 0;
    bit strap_eff = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    iosteer_top dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .as_n_i(as_n), .rw_i(rw),
        .strap_hi_i(strap), .bus_rdy_i(bus_rdy), .mmu_rdy_i(mmu_rdy),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .io_rd_o(io_rd), .io_wr_o(io_wr),
        .port_o(port), .mmu_cs_o(mmu_cs), .strobe_gate_o(gate), .dtack_o(dtack)
    );

    // 0 = memory, 1 = port I/O, 2 = MMU window
    function automatic int exp_tgt(logic [23:0] a, bit s);
        logic [7:0] base;
        base = s ? 8'hFF : 8'h7F;
        if (a[23:16] != base) return 0;
        if (a[15:6] == 10'h3FF) return 2;
        return 1;
    endfunction

    // packs {mem_rd, mem_wr, io_rd, io_wr, mmu_cs, gate}
    function automatic logic [5:0] exp_flags(int t, bit r, bit active_sel);
        logic [5:0] f;
        f = '0;
        if (t == 0) f[5:4] = r ? 2'b10 : 2'b01;
        if (t == 1) f[3:2] = r ? 2'b10 : 2'b01;
        if (t == 2) f[1:0] = {active_sel, 1'b1};
        return f;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
        end
        strap_eff = strap;
    endtask

    // starts at a falling edge; new_strap is applied while strobe is low
    task automatic do_cycle(logic [23:0] a, bit r, int lat, bit wrong_rdy, bit new_strap);
        int  t;
        logic [5:0] f;
        t = exp_tgt(a, strap_eff);
        addr = a; rw = r; as_n = 1'b0;
        @(negedge clk);
        f = exp_flags(t, r, 1'b1);
        // R2 R4 R5: status, MMU select and gate in the clock after strobe falls
        check(t == 2 ? "R4" : (t == 1 ? "R2" : "R5"),
              {mem_rd, mem_wr, io_rd, io_wr, mmu_cs, gate}, f);
        // R3
        check("R3", port, (t == 1) ? a[15:0] : 16'h0);
        check("R7", dtack, 1'b0);
        if (wrong_rdy) begin
            if (t == 2) bus_rdy = 1'b1; else mmu_rdy = 1'b1;
            @(negedge clk);
            // R7: the other ready line does not acknowledge
            check("R7", {dtack, mmu_cs}, {1'b0, (t == 2)});
            bus_rdy = 1'b0; mmu_rdy = 1'b0;
        end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check("R7", dtack, 1'b0);
        end
        strap = new_strap;
        if (t == 2) mmu_rdy = 1'b1; else bus_rdy = 1'b1;
        #1;
        check("R7", dtack, 1'b1);
        @(negedge clk);
        bus_rdy = 1'b0; mmu_rdy = 1'b0;
        #1;
        // R7 held acknowledge, R9 select dropped and gate held
        check("R9", {dtack, mem_rd, mem_wr, io_rd, io_wr, mmu_cs, gate},
              {1'b1, exp_flags(t, r, 1'b0)});
        as_n = 1'b1;
        @(negedge clk);
        // R8
        check("R8", {dtack, mem_rd, mem_wr, io_rd, io_wr, mmu_cs, gate, port}, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D0C5EED));
        repeat (3) @(negedge clk);
        // R1
        check("R1", {dtack, mem_rd, mem_wr, io_rd, io_wr, mmu_cs, gate, port}, '0);
        rst_n = 1'b1;
        idle(2);
        check("R1", {dtack, mem_rd, mem_wr, io_rd, io_wr, mmu_cs, gate, port}, '0);

        // R1: default strap low, 0x7F0002 is I/O
        do_cycle(24'h7F0002, 1'b1, 0, 1'b0, 1'b0);
        // R2 strap low corners
        do_cycle(24'h7F0000, 1'b0, 1, 1'b0, 1'b0);
        do_cycle(24'h7FFFBF, 1'b1, 0, 1'b1, 1'b0);
        // R4 window edges
        do_cycle(24'h7FFFC0, 1'b0, 2, 1'b1, 1'b0);
        do_cycle(24'h7FFFFF, 1'b1, 0, 1'b0, 1'b0);
        // R5 memory outside page, including the other page
        do_cycle(24'h7EFFFF, 1'b1, 0, 1'b1, 1'b0);
        do_cycle(24'hFF0002, 1'b0, 1, 1'b0, 1'b0);
        // R6: strap raised mid-cycle, next cycle after a single idle clock still decodes low
        idle(1);
        do_cycle(24'h7F0010, 1'b1, 0, 1'b0, 1'b1);
        do_cycle(24'hFF0010, 1'b1, 0, 1'b0, 1'b1);
        // R6: after idle clocks, the high strap takes effect
        idle(2);
        do_cycle(24'hFF0002, 1'b1, 0, 1'b0, 1'b1);
        do_cycle(24'hFFFFBF, 1'b0, 0, 1'b0, 1'b1);
        do_cycle(24'hFFFFC0, 1'b1, 1, 1'b1, 1'b1);
        do_cycle(24'h7F0002, 1'b0, 0, 1'b1, 1'b1);

        // R8: strobe removed before any ready
        addr = 24'hFFFFC4; rw = 1'b1; as_n = 1'b0;
        @(negedge clk);
        check("R9", {mmu_cs, gate}, 2'b11);
        as_n = 1'b1;
        @(negedge clk);
        check("R8", {dtack, mmu_cs, gate}, 3'b000);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [23:0] a;
            int sel;
            bit s;
            s = $urandom_range(0, 1);
            strap = s;
            idle(2);
            sel = $urandom_range(0, 3);
            a = 24'($urandom);
            if (sel == 1) a[23:16] = s ? 8'hFF : 8'h7F;
            if (sel == 2) begin a[23:16] = s ? 8'hFF : 8'h7F; a[15:6] = 10'h3FF; end
            if (sel == 3) a[23:16] = s ? 8'h7F : 8'hFF;
            do_cycle(a, 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                     1'($urandom_range(0, 1)), s);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule